// File: doc/BRIEF.md
# DDR Write Strobe and Data Sequencer

This block sits between a DRAM controller and the double-data-rate pad logic on the write path. Each clock the controller offers one rising/falling data pair, and it pulses a command input when it issues a WRITE. The block then produces the full write-side waveform. It drives a low strobe before the first element and a strobe toggle per element. It drives a low strobe after the last element, sets the output enables, and drives the data mask.

Double-rate output is modelled as a pair of data words per clock cycle. The strobe is modelled as four quarter-cycle levels per clock. This lets the block place the first strobe rise early, on time or late relative to the command.

Bursts can be chained back to back with no break in the strobe. A new WRITE can also cut an earlier burst short. A truncation input marks the rest of the current burst for masking.

Top module: `ddr_wr_strobe_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, both output enables, the mask, the strobe levels and both data outputs are zero.
- R2: A WRITE sampled at edge E with the bus idle gives a preamble cycle that starts at edge E+1, with both enables high. The pair offered at edge E+1+k is driven in the cycle that starts at edge E+2+k. The preamble has no strobe high in its first three quarters.
- R3: With the nominal setting (`dqss_sel` = 1 or 3), every data cycle shows strobe levels high, high, low, low. `dqs_ph[0]` is the first quarter.
- R4: With setting 0 (early), the strobe is high in the last quarter of the cycle before each data cycle and in the first quarter of each data cycle. With setting 2 (late), each data cycle shows low, high, high, low. The setting is taken only when a WRITE starts from a preamble, so changes at other times have no effect.
- R5: After the last pair there is exactly one postamble cycle with enables high and all strobe quarters low. The enables drop in the cycle after it.
- R6: With no burst in progress, the enables, the mask, the strobe and the data outputs stay zero whatever data and truncation inputs are applied.
- R7: A WRITE sampled exactly N cycles after a previous WRITE of N pairs makes the new burst's first pair follow that burst's last pair directly, with no preamble, postamble or strobe gap.
- R8: A WRITE sampled x cycles after a previous WRITE, with x less than that burst's length, ends the earlier burst after x pairs. The new burst follows directly.
- R9: A truncation pulse sampled at an edge sets the mask on the pair captured at that edge and on every later pair of the same burst. The next burst starts unmasked.
- R10: A length of 0 gives one pair, and a length above `MAX_PAIRS` gives `MAX_PAIRS` pairs.
- R11: A WRITE sampled N+1 cycles after a WRITE of N pairs gives exactly one cycle with enables high and the strobe low between the two bursts. In the early setting that cycle has only its last quarter high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | WRITE command issued this cycle |
| wr_pairs | input | LW | Burst length in data pairs |
| dqss_sel | input | 2 | First-rise offset: 0 early, 1 nominal, 2 late, 3 nominal |
| trunc | input | 1 | Truncating READ/PRECHARGE: mask rest of burst |
| din_rise | input | DW | Rising-half data offered by the controller |
| din_fall | input | DW | Falling-half data offered by the controller |
| dq_rise | output | DW | Rising-half data driven this cycle |
| dq_fall | output | DW | Falling-half data driven this cycle |
| dm_out | output | 1 | Data mask for the pair driven this cycle |
| dqs_ph | output | 4 | Strobe level per quarter cycle, bit 0 first |
| dq_oe | output | 1 | Data output enable |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
Some rules hold on every cycle, and the in-design assertions watch those. The strobe is never high for more than half a cycle. The release always follows an all-low cycle, and the first enabled cycle is low in its first three quarters. The mask and data are silent while the bus is released, and the latched offset does not move between consecutive data cycles. Exact placement needs directed scenarios, which the bench runs and predicts cycle by cycle from the command and data schedule. These cover the cycle where each pair appears, the per-setting strobe shapes, gapless chaining, cut-short and one-gap chaining, mask start and clearing, and length clamping.

// File: rtl/ddr_wr_strobe_gen.sv
module ddr_wr_strobe_gen #(
  parameter int DW        = 16,
  parameter int MAX_PAIRS = 8,
  parameter int LW        = $clog2(MAX_PAIRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [LW-1:0] wr_pairs,
  input  logic [1:0]    dqss_sel,
  input  logic          trunc,
  input  logic [DW-1:0] din_rise,
  input  logic [DW-1:0] din_fall,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dm_out,
  output logic [3:0]    dqs_ph,
  output logic          dq_oe,
  output logic          dqs_oe
);

  localparam logic [LW-1:0] MAXL = LW'(MAX_PAIRS);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_POST} st_t;

  st_t           a_st, a_nst, b_st;
  logic [LW-1:0] a_cnt, a_ncnt, pend_len, len_eff;
  logic          pend, mflag, next_m, b_dm, fresh;
  logic [1:0]    sel_r, sel_b;
  logic [DW-1:0] a_r, a_f, b_r, b_f;

  always_comb begin
    if (wr_pairs == '0)       len_eff = LW'(1);
    else if (wr_pairs > MAXL) len_eff = MAXL;
    else                      len_eff = wr_pairs;
  end

  always_comb begin
    a_nst  = a_st;
    a_ncnt = a_cnt;
    if (pend) begin
      a_nst  = S_DATA;
      a_ncnt = pend_len - LW'(1);
    end else begin
      case (a_st)
        S_DATA: if (a_cnt != '0) a_ncnt = a_cnt - LW'(1);
                else             a_nst  = S_POST;
        default: a_nst = S_IDLE;
      endcase
    end
    fresh = 1'b0;
    if (wr_cmd) begin
      if (a_nst == S_DATA) a_ncnt = '0;
      else begin
        a_nst = S_PRE;
        fresh = 1'b1;
      end
    end
  end

  assign next_m = trunc | (mflag & ~pend & (a_nst == S_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_st     <= S_IDLE;
      a_cnt    <= '0;
      pend     <= 1'b0;
      pend_len <= '0;
      mflag    <= 1'b0;
      sel_r    <= 2'd1;
      a_r      <= '0;
      a_f      <= '0;
    end else begin
      a_st  <= a_nst;
      a_cnt <= a_ncnt;
      pend  <= wr_cmd;
      mflag <= next_m;
      if (wr_cmd) pend_len <= len_eff;
      if (fresh)  sel_r    <= dqss_sel;
      if (a_nst == S_DATA) begin
        a_r <= din_rise;
        a_f <= din_fall;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_st  <= S_IDLE;
      b_dm  <= 1'b0;
      sel_b <= 2'd1;
      b_r   <= '0;
      b_f   <= '0;
    end else begin
      b_st  <= a_st;
      b_dm  <= mflag & (a_st == S_DATA);
      sel_b <= sel_r;
      b_r   <= a_r;
      b_f   <= a_f;
    end
  end

  logic b_data;
  assign b_data  = (b_st == S_DATA);
  assign dq_rise = b_data ? b_r : '0;
  assign dq_fall = b_data ? b_f : '0;
  assign dm_out  = b_data & b_dm;
  assign dq_oe   = (b_st != S_IDLE);
  assign dqs_oe  = dq_oe;

  always_comb begin
    case (sel_b)
      2'd0:    dqs_ph = {a_st == S_DATA, 2'b00, b_data};
      2'd2:    dqs_ph = b_data ? 4'b0110 : 4'b0000;
      default: dqs_ph = b_data ? 4'b0011 : 4'b0000;
    endcase
  end

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dqs_ph) <= 2);

  assert_preamble_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> dqs_ph[2:0] == 3'b000);

  assert_postamble_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_oe) |-> $past(dqs_ph) == 4'b0000);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_rise == '0 && dq_fall == '0 && dqs_ph == 4'b0000 && !dm_out));

  assert_mask_on_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dm_out |-> dq_oe);

  assert_chain_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> a_st == S_DATA);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt < MAXL);

  assert_offset_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_data && $past(b_st) == S_DATA) |-> $stable(sel_b));

endmodule

// File: tb/ddr_wr_strobe_gen_bench.sv
module ddr_wr_strobe_gen_bench;
  localparam int DW = 16;
  localparam int MP = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_cmd = 1'b0;
  logic [LW-1:0] wr_pairs = '0;
  logic [1:0]    dqss_sel = 2'd1;
  logic          trunc = 1'b0;
  logic [DW-1:0] din_rise = '0, din_fall = '0;
  logic [DW-1:0] dq_rise, dq_fall;
  logic          dm_out, dq_oe, dqs_oe;
  logic [3:0]    dqs_ph;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  ddr_wr_strobe_gen #(.DW(DW), .MAX_PAIRS(MP), .LW(LW)) u_ddr_wr_strobe_gen (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_pairs(wr_pairs),
    .dqss_sel(dqss_sel), .trunc(trunc), .din_rise(din_rise), .din_fall(din_fall),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_out(dm_out), .dqs_ph(dqs_ph),
    .dq_oe(dq_oe), .dqs_oe(dqs_oe));

  always #10 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(string tag, logic [38:0] exp);
    logic [38:0] act;
    act = {dq_oe, dqs_oe, dm_out, dqs_ph, dq_rise, dq_fall};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (oe,oe,dm,ph,rise,fall)", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dval(int i, logic [7:0] seed);
    return {seed, 8'(i)};
  endfunction

  function automatic int eff(int l);
    if (l == 0) return 1;
    if (l > MP) return MP;
    return l;
  endfunction

  task automatic run(string tag, int len1, logic [1:0] sel, int g, int len2, int t, logic [7:0] seed);
    int kind[0:47];
    int bid[0:47];
    int n1, n2, nc;
    for (int c = 0; c < 48; c++) begin kind[c] = 0; bid[c] = 0; end
    n1 = eff(len1);
    n2 = eff(len2);
    kind[1] = 1;
    if (g < 0) begin
      for (int c = 2; c <= n1 + 1; c++) begin kind[c] = 2; bid[c] = 1; end
      kind[n1 + 2] = 1;
      nc = n1 + 4;
    end else if (g <= n1) begin
      for (int c = 2; c <= g + 1; c++) begin kind[c] = 2; bid[c] = 1; end
      for (int c = g + 2; c <= g + 1 + n2; c++) begin kind[c] = 2; bid[c] = 2; end
      kind[g + 2 + n2] = 1;
      nc = g + n2 + 4;
    end else begin
      for (int c = 2; c <= n1 + 1; c++) begin kind[c] = 2; bid[c] = 1; end
      kind[n1 + 2] = 1;
      for (int c = n1 + 3; c <= n1 + 2 + n2; c++) begin kind[c] = 2; bid[c] = 2; end
      kind[n1 + 3 + n2] = 1;
      nc = n1 + n2 + 5;
    end
    for (int i = 0; i < nc; i++) begin
      logic [3:0]    eph;
      logic          edm;
      logic [DW-1:0] er;
      wr_cmd   = (i == 0) || (i == g);
      wr_pairs = LW'((i == g) ? len2 : len1);
      dqss_sel = (i == 0 || i == g) ? sel : ~sel;
      trunc    = (i == t);
      din_rise = dval(i, seed);
      din_fall = ~dval(i, seed);
      tick();
      eph = 4'b0000;
      edm = 1'b0;
      er  = '0;
      if (kind[i] == 1) begin
        if (sel == 2'd0 && kind[i + 1] == 2) eph = 4'b1000;
      end else if (kind[i] == 2) begin
        er = dval(i - 1, seed);
        if (sel == 2'd0)      eph = {kind[i + 1] == 2, 2'b00, 1'b1};
        else if (sel == 2'd2) eph = 4'b0110;
        else                  eph = 4'b0011;
        if (t >= 0 && i - 1 >= t && bid[i] == bid[t + 1]) edm = 1'b1;
      end
      chk($sformatf("%s cycle %0d", tag, i),
          {kind[i] != 0, kind[i] != 0, edm, eph, er, (kind[i] == 2) ? ~er : {DW{1'b0}}});
    end
    wr_cmd = 1'b0;
    trunc  = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    din_rise = 16'h1234;
    repeat (3) tick();
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    tick();
    chk("R1 first cycle after reset", '0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      din_rise = 16'hBEE0 + 16'(i);
      din_fall = 16'h0F0F;
      trunc    = i[0];
      tick();
      chk($sformatf("R6 idle cycle %0d", i), '0);
    end
    trunc = 1'b1;
    tick();
    trunc = 1'b0;
    chk("R6 idle stray truncation", '0);
  endtask

  initial begin
    t_reset();
    run("R2/R3/R5 nominal x4", 4, 2'd1, -1, 0, -1, 8'hA1);
    run("R4 early x4", 4, 2'd0, -1, 0, -1, 8'hA2);
    run("R4 late x3", 3, 2'd2, -1, 0, -1, 8'hA3);
    run("R4 code3 nominal x2", 2, 2'd3, -1, 0, -1, 8'hA4);
    t_idle();
    run("R6 R2 after idle", 2, 2'd1, -1, 0, -1, 8'hA5);
    run("R7 gapless early 2+3", 2, 2'd0, 2, 3, -1, 8'hB1);
    run("R7 gapless nominal 1+2", 1, 2'd1, 1, 2, -1, 8'hB2);
    run("R8 cut 4 after 2", 4, 2'd1, 2, 2, -1, 8'hB3);
    run("R8 cut early 4 after 1", 4, 2'd0, 1, 3, -1, 8'hB4);
    run("R9 mask from pair 2", 4, 2'd1, -1, 0, 2, 8'hC1);
    run("R9 mask cleared on chain", 4, 2'd2, 4, 2, 3, 8'hC2);
    run("R10 zero length", 0, 2'd1, -1, 0, -1, 8'hD1);
    run("R10 clamp length", 15, 2'd1, -1, 0, -1, 8'hD2);
    run("R11 one-gap early", 2, 2'd0, 3, 2, -1, 8'hE1);
    run("R11 one-gap nominal", 3, 2'd1, 4, 1, -1, 8'hE2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..all): actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule